// File: doc/BRIEF.md
# DDR SDRAM Command and Power-State Tracker

This block watches the command side of a DDR SDRAM bus from the device's point of view. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, a bank address and a row/column address. From these it works out which command was issued. It keeps an open or idle flag for each bank and follows the device through its power states.

Each decoded command appears one cycle after the edge that sampled it, together with the bank it targets. Mode-register loads are reported with the register selected and the opcode. Two one-cycle error pulses flag illegal use. One covers protocol misuse: a bank in the wrong state, or a mode load or refresh with rows open. The other covers the clock enable falling while a read or write burst is still running.

A monitor or a behavioural memory model can use these outputs to follow, cycle by cycle, what the controller asked the device to do.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While chip select (`cs_n`) is high at a sampling edge, the command is a no-operation (`cmd_o` = 0) whatever the strobes carry, and no bank state changes.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} is decoded one cycle after the edge into `cmd_o` as follows: 111 NOP=0, 011 ACTIVE=1, 101 READ=2, 100 WRITE=3, 010 PRECHARGE=4, 001 REFRESH=5, 000 MODE-SET=6, 110 BURST-STOP=7.
- R3: ACTIVE to an idle bank sets bit `ba` of `bank_open_o`. For ACTIVE, READ, WRITE and PRECHARGE, `bank_o` reports the `ba` value.
- R4: PRECHARGE with `addr[8]` low closes only bank `ba`. With `addr[8]` high it closes every bank and `ba` has no effect.
- R5: MODE-SET with `ba`=0 writes the base register and with `ba`=1 the extended one. On the write, `mode_wr_o` pulses, `mode_ext_o` equals `ba[0]` and `mode_op_o` equals `addr`. With `ba` of 2 or 3, `proto_err_o` pulses and no write happens.
- R6: ACTIVE to an open bank, or READ/WRITE to an idle bank, pulses `proto_err_o` for one cycle and leaves `bank_open_o` unchanged.
- R7: MODE-SET or REFRESH issued while any bank is open pulses `proto_err_o`, and the mode write is suppressed.
- R8: `cke` low at an edge in normal state (`pwr_state_o`=0) with all banks idle enters precharge power-down (1). With any bank open it enters active power-down (2). While powered down, commands are ignored and banks are held. `cke` high at a later edge returns the state to 0.
- R9: `cke` low together with REFRESH while all banks are idle enters self-refresh (3). `pwr_state_o` returns to 0 as soon as `cke` is high, without waiting for a clock edge.
- R10: `cke` low at any of the BURST_LEN (4) edges after an accepted READ or WRITE pulses `cke_err_o`. A BURST-STOP ends that window early.
- R11: After reset, `cmd_o`, `bank_open_o`, `pwr_state_o` and both error pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row/column address and opcode |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank targeted by the last bank command |
| bank_open_o | output | 4 | Per-bank open flags |
| pwr_state_o | output | 2 | 0 normal, 1 precharge PD, 2 active PD, 3 self-refresh |
| mode_wr_o | output | 1 | Mode-register write pulse |
| mode_ext_o | output | 1 | 1 when the extended register was written |
| mode_op_o | output | 12 | Opcode of the last mode write |
| proto_err_o | output | 1 | Protocol-error pulse |
| cke_err_o | output | 1 | Clock-enable-during-burst error pulse |

## Verification
The decoder is driven with each strobe pattern under a low chip select, and with an ACTIVE pattern under a high one. This separates true decode from masking. Bank tests alternate single-bank and all-bank precharges on several open banks, so a wrong address bit or a mask slip shows up as a stray open flag. Power tests enter power-down with banks idle and with a row open, and enter self-refresh with a simultaneous refresh. These tell the three entry paths apart and check the asynchronous exit from self-refresh between clock edges. Clock-enable drops on the last and first edges outside a burst window, and after a burst stop, locate the window edges exactly.

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker #(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int BURST_LEN   = 4,
  parameter int PRE_ALL_BIT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ADDR_W-1:0]      addr,
  output logic [2:0]             cmd_o,
  output logic [BA_W-1:0]        bank_o,
  output logic [(1<<BA_W)-1:0]   bank_open_o,
  output logic [1:0]             pwr_state_o,
  output logic                   mode_wr_o,
  output logic                   mode_ext_o,
  output logic [ADDR_W-1:0]      mode_op_o,
  output logic                   proto_err_o,
  output logic                   cke_err_o
);
  localparam int NBANK = 1 << BA_W;
  localparam int CW    = $clog2(BURST_LEN + 1);

  typedef enum logic [2:0] {
    C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
    C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_BST = 3'd7
  } cmd_t;

  typedef enum logic [1:0] {
    P_NORM = 2'd0, P_PPD = 2'd1, P_APD = 2'd2, P_SR = 2'd3
  } pwr_t;

  cmd_t             raw, eff;
  pwr_t             pst, pst_d;
  logic [NBANK-1:0] bank_q, bank_d, sel;
  logic [CW-1:0]    cnt, cnt_d;

  wire normal   = (pst == P_NORM);
  wire entry    = normal && !cke;
  wire busy     = (cnt != '0);
  wire any_open = |bank_q;
  wire tgt_open = |(bank_q & sel);
  assign sel = NBANK'(1) << ba;

  always_comb begin
    raw = C_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  raw = C_ACT;
        3'b101:  raw = C_RD;
        3'b100:  raw = C_WR;
        3'b010:  raw = C_PRE;
        3'b001:  raw = C_REF;
        3'b000:  raw = C_MRS;
        3'b110:  raw = C_BST;
        default: raw = C_NOP;
      endcase
    end
  end

  always_comb begin
    if (!normal)   eff = C_NOP;
    else if (!cke) eff = (raw == C_REF) ? C_REF : C_NOP;
    else           eff = raw;
  end

  wire is_rw    = (eff == C_RD) || (eff == C_WR);
  wire err_act  = (eff == C_ACT) && tgt_open;
  wire err_rw   = is_rw && !tgt_open;
  wire err_open = ((eff == C_REF) || (eff == C_MRS)) && any_open;
  wire err_msel = (eff == C_MRS) && (ba > BA_W'(1));
  wire perr     = err_act || err_rw || err_open || err_msel;
  wire bank_cmd = (eff == C_ACT) || is_rw || (eff == C_PRE);

  always_comb begin
    bank_d = bank_q;
    if (!perr) begin
      if (eff == C_ACT)      bank_d = bank_q | sel;
      else if (eff == C_PRE) bank_d = addr[PRE_ALL_BIT] ? '0 : (bank_q & ~sel);
    end
  end

  always_comb begin
    pst_d = pst;
    if (normal) begin
      if (!cke) begin
        if ((eff == C_REF) && !any_open) pst_d = P_SR;
        else if (any_open)               pst_d = P_APD;
        else                             pst_d = P_PPD;
      end
    end else if (cke) begin
      pst_d = P_NORM;
    end
  end

  always_comb begin
    cnt_d = cnt;
    if (entry)                cnt_d = '0;
    else if (is_rw && !perr)  cnt_d = CW'(BURST_LEN);
    else if (eff == C_BST)    cnt_d = '0;
    else if (busy)            cnt_d = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst         <= P_NORM;
      bank_q      <= '0;
      cnt         <= '0;
      cmd_o       <= 3'd0;
      bank_o      <= '0;
      mode_wr_o   <= 1'b0;
      mode_ext_o  <= 1'b0;
      mode_op_o   <= '0;
      proto_err_o <= 1'b0;
      cke_err_o   <= 1'b0;
    end else begin
      pst         <= pst_d;
      bank_q      <= bank_d;
      cnt         <= cnt_d;
      cmd_o       <= eff;
      proto_err_o <= perr;
      cke_err_o   <= entry && busy;
      mode_wr_o   <= (eff == C_MRS) && !perr;
      if (bank_cmd) bank_o <= ba;
      if ((eff == C_MRS) && !perr) begin
        mode_ext_o <= ba[0];
        mode_op_o  <= addr;
      end
    end
  end

  assign bank_open_o = bank_q;
  assign pwr_state_o = ((pst == P_SR) && cke) ? P_NORM : pst;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int PRE_ALL_BIT = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cke,
  input logic                 cs_n,
  input logic [ADDR_W-1:0]    addr,
  input logic [2:0]           cmd_o,
  input logic [(1<<BA_W)-1:0] bank_open_o,
  input logic [1:0]           pwr_state_o,
  input logic                 mode_wr_o,
  input logic                 proto_err_o,
  input logic                 cke_err_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_o == 3'd0));

  assert_open_needs_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((bank_open_o & ~$past(bank_open_o)) != '0)) |-> (cmd_o == 3'd1 && !proto_err_o));

  assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cmd_o == 3'd4 && $past(addr[PRE_ALL_BIT])) |-> (bank_open_o == '0));

  assert_mode_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_o |-> (cmd_o == 3'd6 && !proto_err_o));

  assert_err_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && proto_err_o) |-> (bank_open_o == $past(bank_open_o)));

  assert_ppd_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd1) |-> (bank_open_o == '0));

  assert_apd_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd2) |-> (bank_open_o != '0));

  assert_sr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd3) |-> (bank_open_o == '0));

  assert_cke_err_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_err_o && !cke) |-> (pwr_state_o != 2'd0));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .PRE_ALL_BIT(PRE_ALL_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .addr(addr),
  .cmd_o(cmd_o), .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o),
  .mode_wr_o(mode_wr_o), .proto_err_o(proto_err_o), .cke_err_o(cke_err_o)
);

// File: tb/tb_ddr_cmd_tracker.sv
module tb_ddr_cmd_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [2:0] cmd_o;
  logic [1:0] bank_o, pwr_state_o;
  logic [3:0] bank_open_o;
  logic mode_wr_o, mode_ext_o, proto_err_o, cke_err_o;
  logic [11:0] mode_op_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  ddr_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_o(bank_o), .bank_open_o(bank_open_o), .pwr_state_o(pwr_state_o),
    .mode_wr_o(mode_wr_o), .mode_ext_o(mode_ext_o), .mode_op_o(mode_op_o),
    .proto_err_o(proto_err_o), .cke_err_o(cke_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a negedge, wait one rising edge, return at the following negedge
  task automatic issue(input logic [2:0] c, input logic [1:0] b, input logic [11:0] a,
                       input logic k, input logic cs = 1'b0);
    cs_n = cs; ba = b; addr = a; cke = k;
    case (c)
      3'd1: {ras_n, cas_n, we_n} = 3'b011;
      3'd2: {ras_n, cas_n, we_n} = 3'b101;
      3'd3: {ras_n, cas_n, we_n} = 3'b100;
      3'd4: {ras_n, cas_n, we_n} = 3'b010;
      3'd5: {ras_n, cas_n, we_n} = 3'b001;
      3'd6: {ras_n, cas_n, we_n} = 3'b000;
      3'd7: {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 cmd", cmd_o, 0);
    chk("R11 banks", bank_open_o, 0);
    chk("R11 pwr", pwr_state_o, 0);
    chk("R11 errs", {proto_err_o, cke_err_o}, 0);
  endtask

  task automatic t_cs_mask;
    issue(3'd1, 2'd2, 12'h0, 1'b1, 1'b1);
    chk("R1 masked cmd", cmd_o, 0);
    chk("R1 masked bank", bank_open_o, 0);
  endtask

  task automatic t_banks;
    issue(3'd1, 2'd0, 12'h0, 1'b1);
    chk("R2 act code", cmd_o, 1);
    chk("R3 open b0", bank_open_o, 4'b0001);
    issue(3'd1, 2'd2, 12'h0, 1'b1);
    chk("R3 bank_o", bank_o, 2);
    chk("R3 open b2", bank_open_o, 4'b0101);
    issue(3'd2, 2'd2, 12'h0, 1'b1);
    chk("R2 read code", {cmd_o, proto_err_o}, {3'd2, 1'b0});
    issue(3'd7, 2'd0, 12'h0, 1'b1);
    chk("R2 bst code", cmd_o, 7);
    issue(3'd3, 2'd0, 12'h0, 1'b1);
    chk("R2 write code", cmd_o, 3);
    issue(3'd7, 2'd0, 12'h0, 1'b1);
    issue(3'd4, 2'd2, 12'h000, 1'b1);
    chk("R2 pre code", cmd_o, 4);
    chk("R4 single pre", bank_open_o, 4'b0001);
    issue(3'd1, 2'd3, 12'h0, 1'b1);
    chk("R3 open b3", bank_open_o, 4'b1001);
    issue(3'd4, 2'd0, 12'h100, 1'b1);
    chk("R4 pre all", bank_open_o, 4'b0000);
  endtask

  task automatic t_errors;
    issue(3'd1, 2'd1, 12'h0, 1'b1);
    issue(3'd1, 2'd1, 12'h0, 1'b1);
    chk("R6 act open err", {proto_err_o, bank_open_o}, {1'b1, 4'b0010});
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    chk("R6 pulse ends", proto_err_o, 0);
    issue(3'd2, 2'd3, 12'h0, 1'b1);
    chk("R6 read idle err", {proto_err_o, bank_open_o}, {1'b1, 4'b0010});
    issue(3'd5, 2'd0, 12'h0, 1'b1);
    chk("R7 ref open err", proto_err_o, 1);
    issue(3'd6, 2'd0, 12'h0AA, 1'b1);
    chk("R7 mrs open err", {proto_err_o, mode_wr_o}, {1'b1, 1'b0});
    issue(3'd4, 2'd0, 12'h100, 1'b1);
  endtask

  task automatic t_mode;
    issue(3'd6, 2'd0, 12'h123, 1'b1);
    chk("R5 base write", {cmd_o, mode_wr_o, mode_ext_o, mode_op_o}, {3'd6, 1'b1, 1'b0, 12'h123});
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    chk("R5 pulse ends", mode_wr_o, 0);
    issue(3'd6, 2'd1, 12'h045, 1'b1);
    chk("R5 ext write", {mode_wr_o, mode_ext_o, mode_op_o}, {1'b1, 1'b1, 12'h045});
    issue(3'd6, 2'd2, 12'h777, 1'b1);
    chk("R5 bad select", {proto_err_o, mode_wr_o}, {1'b1, 1'b0});
    issue(3'd5, 2'd0, 12'h0, 1'b1);
    chk("R2 refresh idle", {cmd_o, proto_err_o}, {3'd5, 1'b0});
  endtask

  task automatic t_powerdown;
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R8 enter ppd", pwr_state_o, 1);
    issue(3'd1, 2'd0, 12'h0, 1'b0);
    chk("R8 cmd ignored", {cmd_o, bank_open_o, pwr_state_o}, {3'd0, 4'b0000, 2'd1});
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    chk("R8 exit ppd", pwr_state_o, 0);
    issue(3'd1, 2'd1, 12'h0, 1'b1);
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R8 enter apd", {pwr_state_o, bank_open_o}, {2'd2, 4'b0010});
    issue(3'd4, 2'd1, 12'h100, 1'b1);
    chk("R8 exit apd banks held", {pwr_state_o, bank_open_o, cmd_o}, {2'd0, 4'b0010, 3'd0});
    issue(3'd4, 2'd1, 12'h100, 1'b1);
  endtask

  task automatic t_selfrefresh;
    issue(3'd5, 2'd0, 12'h0, 1'b0);
    chk("R9 enter sr", {pwr_state_o, cmd_o}, {2'd3, 3'd5});
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R9 stay sr", pwr_state_o, 3);
    cke = 1'b1;
    #1;
    chk("R9 async exit", pwr_state_o, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 after edge", pwr_state_o, 0);
  endtask

  task automatic t_burst;
    issue(3'd1, 2'd0, 12'h0, 1'b1);
    issue(3'd2, 2'd0, 12'h0, 1'b1);
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R10 first edge err", {cke_err_o, pwr_state_o}, {1'b1, 2'd2});
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    issue(3'd3, 2'd0, 12'h0, 1'b1);
    for (int i = 0; i < 3; i++) issue(3'd0, 2'd0, 12'h0, 1'b1);
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R10 last edge err", cke_err_o, 1);
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    issue(3'd2, 2'd0, 12'h0, 1'b1);
    for (int i = 0; i < 4; i++) issue(3'd0, 2'd0, 12'h0, 1'b1);
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R10 past window", {cke_err_o, pwr_state_o}, {1'b0, 2'd2});
    issue(3'd0, 2'd0, 12'h0, 1'b1);
    issue(3'd3, 2'd0, 12'h0, 1'b1);
    issue(3'd7, 2'd0, 12'h0, 1'b1);
    issue(3'd0, 2'd0, 12'h0, 1'b0);
    chk("R10 bst ends window", cke_err_o, 0);
    issue(3'd0, 2'd0, 12'h0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cs_mask();
    t_banks();
    t_errors();
    t_mode();
    t_powerdown();
    t_selfrefresh();
    t_burst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule